// File: doc/BRIEF.md
# Key-Locked Flash Program and Erase Controller

This block sits between a simple register bus and an on-chip flash array built from 128-byte pages. Software talks to it through four registers: a key register, a control register, an address register and a status register. The control register stays locked until two fixed key words arrive in the right order. Once it is unlocked, software can erase one page at a time or program single 16-bit halfwords. Every operation keeps the status busy flag set for a fixed number of cycles. When the operation finishes, the controller raises an end-of-operation flag and sends one write or erase strobe to the array.

The main array lives at `MAIN_BASE` (0x0800_0000 by default). Reads of the same cells are also answered through an alias window at address 0. This array has two unusual rules. First, an erase clears cells to 0x00, not 0xFF. Second, a program or erase can go through the full sequence and still leave the cells unchanged. This happens when an erase targets an address in the alias window, or when a halfword program targets an address that is not 4-byte aligned. In both cases the status and address registers behave exactly as they would for an effective operation.

Top module: `flash_keyctl`

## Requirements
- R1: After reset the control register reads 0x80 (bit 7 = locked, bit 1 = page-erase mode, bit 0 = program mode) and the status register reads 0 (bit 0 busy, bit 1 end-of-operation, bit 2 access-size error, bit 3 busy-write error). Register offsets from `REG_BASE` are: key 0x0, control 0x4, address 0x8, status 0xC.
- R2: Control register writes are ignored while the controller is locked. Writing 0x4567_0123 and then 0xCDEF_89AB to the key register unlocks it, after which the control register reads 0x00.
- R3: A key write with a wrong value, or the two keys written out of order, keeps the controller locked until the next reset, even if the correct sequence follows.
- R4: Writing the control register with bit 7 set re-locks the controller and clears both mode bits. After that, control writes and flash programming are ignored until the key sequence is written again.
- R5: With page-erase mode set, writing the control register with bits 1 and 6 set starts an erase of the page named in the address register. If that address lies in the main region, all 32 words of the page become 0x0000_0000 and other pages keep their contents.
- R6: An erase whose address lies in the alias window runs the full timing and sets end-of-operation, but leaves the array unchanged.
- R7: With program mode set, a 16-bit bus write to a 4-byte-aligned address in either the main region or the alias window replaces that halfword with bits 15:0 of the write data.
- R8: A 16-bit program at an address that is 2 modulo 4 loads that address into the address register and sets end-of-operation, but leaves the cells unchanged.
- R9: In program mode, a byte-size (size 0) or word-size (size 2) write to the flash sets the size-error flag, starts no operation and writes nothing. Size 1 means halfword.
- R10: Busy reads 1 from the cycle after an operation starts, for `OP_CYCLES` cycles. End-of-operation is set as busy falls, and writing 1 to a status flag bit clears that flag.
- R11: A control register write during an operation is ignored and sets the busy-write error flag.
- R12: A read at alias address A returns the same word as a read at `MAIN_BASE`+A. Bus reads return data on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| arr_raddr | output | WORD_AW | Word index presented to the array read port |
| arr_rdata | input | 32 | Array read data (combinational) |
| arr_prog | output | 1 | One-cycle halfword program strobe |
| arr_hidx | output | HALF_AW | Halfword index being programmed |
| arr_wdata | output | 16 | Halfword being programmed |
| arr_erase | output | 1 | One-cycle page erase strobe |
| arr_page | output | PAGE_AW | Page index being erased |

## Verification
The hardest cases to reach are the ones where a full operation runs and yet the array must stay untouched. These are an erase aimed at the alias window and a program at a 2-modulo-4 address. Both require the controller to be unlocked, in the right mode and idle before the request lands. The stimulus unlocks, selects the mode and waits for busy to clear. It then issues the request and reads both the status and the neighbouring words, so that a missing end-of-operation or a stray write both show up. The busy-write error is reached by sending a control write exactly two cycles after a program request, while the operation is still running. Permanent lockout is reached by resetting mid-test and feeding wrong or reordered keys before the correct ones.

// File: rtl/flash_keyctl_pkg.sv
package flash_keyctl_pkg;
  localparam int unsigned PAGE_BYTES = 128;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    KS_LOCKED,
    KS_FIRST_OK,
    KS_OPEN,
    KS_BARRED
  } key_state_e;

  localparam logic [31:0] KEY_ONE = 32'h4567_0123;
  localparam logic [31:0] KEY_TWO = 32'hCDEF_89AB;

  localparam logic [3:0] OFS_KEY  = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_ADDR = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;

  localparam int unsigned CTL_PG    = 0;
  localparam int unsigned CTL_PER   = 1;
  localparam int unsigned CTL_START = 6;
  localparam int unsigned CTL_LOCK  = 7;

  localparam int unsigned ST_BSY  = 0;
  localparam int unsigned ST_EOP  = 1;
  localparam int unsigned ST_SZE  = 2;
  localparam int unsigned ST_BWE  = 3;
endpackage

// File: rtl/flash_keyctl_rstsync.sv
module flash_keyctl_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/flash_keyctl_keylock.sv
module flash_keyctl_keylock
  import flash_keyctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        unlocked,
  output logic        barred
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED:   if (key_wr) state_d = (key_val == KEY_ONE) ? KS_FIRST_OK : KS_BARRED;
      KS_FIRST_OK: if (key_wr) state_d = (key_val == KEY_TWO) ? KS_OPEN : KS_BARRED;
      KS_OPEN:     if (relock) state_d = KS_LOCKED;
      default:     state_d = KS_BARRED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);
  assign barred   = (state_q == KS_BARRED);
endmodule

// File: rtl/flash_keyctl_opseq.sv
module flash_keyctl_opseq #(
  parameter int unsigned OP_CYCLES = 6,
  parameter int unsigned ARR_AW    = 10,
  parameter int unsigned PG_SH     = 7,
  parameter logic [31:0] MAIN_BASE = 32'h0800_0000,
  localparam int unsigned CNT_W    = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    erase_i,
  input  logic [31:0]             addr_i,
  input  logic [15:0]             data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    prog_o,
  output logic                    erase_o,
  output logic [ARR_AW-2:0]       hidx_o,
  output logic [ARR_AW-PG_SH-1:0] page_o,
  output logic [15:0]             wdata_o
);
  localparam logic [31-ARR_AW:0] MAIN_HI = MAIN_BASE[31:ARR_AW];

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ers_q, ers_d;
  logic [31:0]      addr_q, addr_d;
  logic [15:0]      data_q, data_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ers_d  = ers_q;
    addr_d = addr_q;
    data_d = data_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(OP_CYCLES - 1);
      ers_d  = erase_i;
      addr_d = addr_i;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ers_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ers_q  <= ers_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = busy_q && (cnt_q == '0);
  assign erase_o = done_o && ers_q && (addr_q[31:ARR_AW] == MAIN_HI);
  assign prog_o  = done_o && !ers_q && (addr_q[1:0] == 2'b00);
  assign hidx_o  = addr_q[ARR_AW-1:1];
  assign page_o  = addr_q[ARR_AW-1:PG_SH];
  assign wdata_o = data_q;
endmodule

// File: rtl/flash_keyctl.sv
module flash_keyctl
  import flash_keyctl_pkg::*;
#(
  parameter int unsigned PAGES     = 8,
  parameter int unsigned OP_CYCLES = 6,
  parameter logic [31:0] MAIN_BASE = 32'h0800_0000,
  parameter logic [31:0] REG_BASE  = 32'h4002_2000,
  localparam int unsigned PG_SH    = $clog2(PAGE_BYTES),
  localparam int unsigned ARR_AW   = $clog2(PAGES * PAGE_BYTES),
  localparam int unsigned WORD_AW  = ARR_AW - 2,
  localparam int unsigned HALF_AW  = ARR_AW - 1,
  localparam int unsigned PAGE_AW  = ARR_AW - PG_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [31:0]        bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [WORD_AW-1:0] arr_raddr,
  input  logic [31:0]        arr_rdata,
  output logic               arr_prog,
  output logic [HALF_AW-1:0] arr_hidx,
  output logic [15:0]        arr_wdata,
  output logic               arr_erase,
  output logic [PAGE_AW-1:0] arr_page
);
  localparam logic [31-ARR_AW:0] MAIN_HI = MAIN_BASE[31:ARR_AW];
  localparam logic [27:0]        REG_HI  = REG_BASE[31:4];

  logic rst_ni;
  logic unlocked, barred, busy, seq_done;
  logic pg_q, pg_d, per_q, per_d;
  logic eop_q, eop_d, sze_q, sze_d, bwe_q, bwe_d;
  logic [31:0] addr_q, addr_d, rdata_q, rdata_d;
  logic is_reg, is_arr, wr_en, rd_en;
  logic key_wr, ctl_wr, adr_wr, sts_wr, fl_wr, can_act;
  logic prog_start, erase_start, size_bad, relock;

  flash_keyctl_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_ni)
  );

  assign is_reg  = (bus_addr[31:4] == REG_HI);
  assign is_arr  = (bus_addr[31:ARR_AW] == MAIN_HI) || (bus_addr[31:ARR_AW] == '0);
  assign wr_en   = bus_valid && bus_write;
  assign rd_en   = bus_valid && !bus_write;
  assign key_wr  = wr_en && is_reg && (bus_addr[3:0] == OFS_KEY);
  assign ctl_wr  = wr_en && is_reg && (bus_addr[3:0] == OFS_CTRL);
  assign adr_wr  = wr_en && is_reg && (bus_addr[3:0] == OFS_ADDR);
  assign sts_wr  = wr_en && is_reg && (bus_addr[3:0] == OFS_STAT);
  assign fl_wr   = wr_en && is_arr;
  assign can_act = unlocked && !busy;

  assign prog_start  = fl_wr && can_act && pg_q && (bus_size == SZ_HALF);
  assign size_bad    = fl_wr && can_act && pg_q && (bus_size != SZ_HALF);
  assign erase_start = ctl_wr && can_act && !bus_wdata[CTL_LOCK]
                       && bus_wdata[CTL_PER] && bus_wdata[CTL_START];
  assign relock      = ctl_wr && can_act && bus_wdata[CTL_LOCK];

  flash_keyctl_keylock u_key (
    .clk(clk), .rst_n(rst_ni), .key_wr(key_wr), .key_val(bus_wdata),
    .relock(relock), .unlocked(unlocked), .barred(barred)
  );

  flash_keyctl_opseq #(
    .OP_CYCLES(OP_CYCLES), .ARR_AW(ARR_AW), .PG_SH(PG_SH), .MAIN_BASE(MAIN_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_ni),
    .start_i(prog_start || erase_start), .erase_i(erase_start),
    .addr_i(prog_start ? bus_addr : addr_q), .data_i(bus_wdata[15:0]),
    .busy_o(busy), .done_o(seq_done), .prog_o(arr_prog), .erase_o(arr_erase),
    .hidx_o(arr_hidx), .page_o(arr_page), .wdata_o(arr_wdata)
  );

  assign arr_raddr = bus_addr[ARR_AW-1:2];

  always_comb begin
    pg_d    = pg_q;
    per_d   = per_q;
    addr_d  = addr_q;
    eop_d   = eop_q;
    sze_d   = sze_q;
    bwe_d   = bwe_q;
    rdata_d = rdata_q;
    if (sts_wr) begin
      if (bus_wdata[ST_EOP]) eop_d = 1'b0;
      if (bus_wdata[ST_SZE]) sze_d = 1'b0;
      if (bus_wdata[ST_BWE]) bwe_d = 1'b0;
    end
    if (seq_done) eop_d = 1'b1;
    if (ctl_wr) begin
      if (busy) begin
        bwe_d = 1'b1;
      end else if (unlocked) begin
        pg_d  = bus_wdata[CTL_PG]  && !bus_wdata[CTL_LOCK];
        per_d = bus_wdata[CTL_PER] && !bus_wdata[CTL_LOCK];
      end
    end
    if (adr_wr && can_act) addr_d = bus_wdata;
    if (prog_start)        addr_d = bus_addr;
    if (size_bad)          sze_d  = 1'b1;
    if (rd_en) begin
      rdata_d = '0;
      if (is_reg) begin
        unique case (bus_addr[3:0])
          OFS_CTRL: rdata_d = {24'd0, !unlocked, 5'd0, per_q, pg_q};
          OFS_ADDR: rdata_d = addr_q;
          OFS_STAT: rdata_d = {28'd0, bwe_q, sze_q, eop_q, busy};
          default:  rdata_d = '0;
        endcase
      end else if (is_arr) begin
        rdata_d = arr_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q    <= 1'b0;
      per_q   <= 1'b0;
      addr_q  <= '0;
      eop_q   <= 1'b0;
      sze_q   <= 1'b0;
      bwe_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      pg_q    <= pg_d;
      per_q   <= per_d;
      addr_q  <= addr_d;
      eop_q   <= eop_d;
      sze_q   <= sze_d;
      bwe_q   <= bwe_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/flash_keyctl_chk.sv
module flash_keyctl_chk #(
  parameter int unsigned ARR_AW    = 10,
  parameter logic [31:0] MAIN_BASE = 32'h0800_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        unlocked,
  input logic        barred,
  input logic        busy,
  input logic        pg,
  input logic        per,
  input logic        eop,
  input logic        sze,
  input logic        bwe,
  input logic        ctl_wr,
  input logic        fl_wr,
  input logic [1:0]  bus_size,
  input logic [31:0] addr_q,
  input logic        arr_prog,
  input logic        arr_erase
);
  // R2
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(pg) && $stable(per)));

  // R3
  barred_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    barred |=> (barred && !unlocked));

  // R5
  erase_main_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> (addr_q[31:ARR_AW] == MAIN_BASE[31:ARR_AW]));

  // R8
  prog_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |-> (addr_q[1:0] == 2'b00));

  // R9
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr && unlocked && pg && !busy && bus_size != 2'd1) |=> (sze && !busy));

  // R10
  eop_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eop);

  // R11
  busy_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && busy) |=> (bwe && $stable(pg) && $stable(per)));
endmodule

bind flash_keyctl flash_keyctl_chk #(.ARR_AW(ARR_AW), .MAIN_BASE(MAIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_ni), .unlocked(unlocked), .barred(barred), .busy(busy),
  .pg(pg_q), .per(per_q), .eop(eop_q), .sze(sze_q), .bwe(bwe_q),
  .ctl_wr(ctl_wr), .fl_wr(fl_wr), .bus_size(bus_size), .addr_q(addr_q),
  .arr_prog(arr_prog), .arr_erase(arr_erase)
);

// File: tb/flash_keyctl_bench.sv
module flash_keyctl_bench;
  localparam int PAGES = 8;
  localparam int OPC   = 6;
  localparam int AW    = $clog2(PAGES * 128);
  localparam int WORDS = PAGES * 32;
  localparam logic [31:0] MAIN = 32'h0800_0000;
  localparam logic [31:0] RB   = 32'h4002_2000;
  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;
  localparam logic [31:0] A_KEY = RB, A_CTL = RB + 4, A_ADR = RB + 8, A_STS = RB + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_valid = 1'b0, b_write = 1'b0;
  logic [31:0] b_addr = '0, b_wdata = '0;
  logic [1:0]  b_size = 2'd2;
  logic [31:0] bus_rdata, arr_rdata;
  logic [AW-3:0] arr_raddr;
  logic arr_prog, arr_erase;
  logic [AW-2:0] arr_hidx;
  logic [15:0] arr_wdata;
  logic [AW-8:0] arr_page;
  int n_chk = 0, n_err = 0;
  logic [31:0] f_mem [WORDS];
  logic [31:0] m_mem [WORDS];

  always #2.5 clk = ~clk;

  flash_keyctl #(.PAGES(PAGES), .OP_CYCLES(OPC), .MAIN_BASE(MAIN), .REG_BASE(RB)) u_flash_keyctl (
    .clk(clk), .rst_n(rst_n), .bus_valid(b_valid), .bus_write(b_write), .bus_addr(b_addr),
    .bus_size(b_size), .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .arr_raddr(arr_raddr),
    .arr_rdata(arr_rdata), .arr_prog(arr_prog), .arr_hidx(arr_hidx), .arr_wdata(arr_wdata),
    .arr_erase(arr_erase), .arr_page(arr_page)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'hA5A5_0000 ^ (32'(i) * 32'h0001_0203);
  endfunction

  initial for (int i = 0; i < WORDS; i++) begin f_mem[i] = init_word(i); m_mem[i] = init_word(i); end

  // array model driven by the DUT strobes
  assign arr_rdata = f_mem[arr_raddr];
  always @(posedge clk) begin
    if (arr_erase) for (int j = 0; j < 32; j++) f_mem[int'(arr_page) * 32 + j] = '0;
    if (arr_prog) begin
      if (arr_hidx[0]) f_mem[arr_hidx[AW-2:1]][31:16] = arr_wdata;
      else             f_mem[arr_hidx[AW-2:1]][15:0]  = arr_wdata;
    end
  end

  // behavioural reference model
  int m_key, m_left;
  bit m_pg, m_per, m_eop, m_sze, m_bwe, m_ers, m_rdv;
  logic [31:0] m_adr, m_opa, m_exp;
  logic [15:0] m_opd;

  function automatic bit in_main(logic [31:0] a);
    return a[31:AW] == MAIN[31:AW];
  endfunction
  function automatic bit in_arr(logic [31:0] a);
    return in_main(a) || (a[31:AW] == '0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_left = 0; m_pg = 0; m_per = 0; m_eop = 0; m_sze = 0; m_bwe = 0;
      m_adr = '0; m_rdv = 0;
    end else begin
      bit busy_pre, go;
      busy_pre = (m_left > 0);
      go = 0;
      m_rdv = b_valid && !b_write;
      if (m_rdv) begin
        m_exp = '0;
        if (b_addr[31:4] == RB[31:4]) begin
          case (b_addr[3:0])
            4'h4: m_exp = {24'd0, m_key != 2, 5'd0, m_per, m_pg};
            4'h8: m_exp = m_adr;
            4'hC: m_exp = {28'd0, m_bwe, m_sze, m_eop, busy_pre};
            default: m_exp = '0;
          endcase
        end else if (in_arr(b_addr)) m_exp = m_mem[b_addr[AW-1:2]];
      end
      if (b_valid && b_write) begin
        if (b_addr == A_KEY) begin
          if (m_key == 0) m_key = (b_wdata == K1) ? 1 : 3;
          else if (m_key == 1) m_key = (b_wdata == K2) ? 2 : 3;
        end else if (b_addr == A_CTL) begin
          if (busy_pre) m_bwe = 1;
          else if (m_key == 2) begin
            if (b_wdata[7]) begin m_pg = 0; m_per = 0; m_key = 0; end
            else begin
              m_pg = b_wdata[0]; m_per = b_wdata[1];
              if (b_wdata[1] && b_wdata[6]) begin go = 1; m_ers = 1; m_opa = m_adr; end
            end
          end
        end else if (b_addr == A_ADR) begin
          if (m_key == 2 && !busy_pre) m_adr = b_wdata;
        end else if (b_addr == A_STS) begin
          if (b_wdata[1]) m_eop = 0;
          if (b_wdata[2]) m_sze = 0;
          if (b_wdata[3]) m_bwe = 0;
        end else if (in_arr(b_addr) && m_key == 2 && m_pg && !busy_pre) begin
          if (b_size == 2'd1) begin
            go = 1; m_ers = 0; m_opa = b_addr; m_opd = b_wdata[15:0]; m_adr = b_addr;
          end else m_sze = 1;
        end
      end
      if (busy_pre) begin
        if (m_left == 1) begin
          if (m_ers && in_main(m_opa))
            for (int j = 0; j < 32; j++) m_mem[int'(m_opa[AW-1:7]) * 32 + j] = '0;
          if (!m_ers && m_opa[1:0] == 2'b00) m_mem[m_opa[AW-1:2]][15:0] = m_opd;
          m_eop = 1;
        end
        m_left = m_left - 1;
      end
      if (go) m_left = OPC;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    bit same;
    same = 1;
    for (int i = 0; i < WORDS; i++) if (f_mem[i] !== m_mem[i]) same = 0;
    n_chk++;
    if (!same) begin
      n_err++;
      $display("FAIL R5/R7 array differs from model actual=mismatch expected=match t=%0t", $time);
    end
    if (rst_n && m_rdv) begin
      n_chk++;
      if (bus_rdata !== m_exp) begin
        n_err++;
        $display("FAIL R12 read data actual=%h expected=%h t=%0t", bus_rdata, m_exp, $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, logic [1:0] s = 2'd2);
    @(negedge clk);
    b_valid = 1; b_write = 1; b_addr = a; b_wdata = d; b_size = s;
    @(negedge clk);
    b_valid = 0; b_write = 0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    b_valid = 1; b_write = 0; b_addr = a; b_size = 2'd2;
    @(negedge clk);
    d = bus_rdata;
    b_valid = 0;
  endtask

  task automatic wait_op();
    repeat (OPC + 2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    report();
  end

  initial begin
    logic [31:0] v, v2;
    do_reset();
    // R1
    rd(A_CTL, v); chk("R1 ctrl after reset", v, 32'h80);
    rd(A_STS, v); chk("R1 status after reset", v, 32'h0);
    // R2
    wr(A_CTL, 32'h1); rd(A_CTL, v); chk("R2 locked ctrl write ignored", v, 32'h80);
    wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTL, v); chk("R2 unlocked ctrl", v, 32'h0);
    // R12
    rd(MAIN + 20, v); rd(32'h14, v2);
    chk("R12 alias equals main", v2, v); chk("R12 main content", v, init_word(5));
    // R7 and R10
    wr(A_CTL, 32'h1); wr(MAIN + 32'h10, 32'hBEEF, 2'd1);
    rd(A_STS, v); chk("R10 busy during op", v, 32'h1);
    wait_op();
    rd(A_STS, v); chk("R10 eop after op", v, 32'h2);
    rd(MAIN + 32'h10, v); chk("R7 aligned program", v, (init_word(4) & 32'hFFFF_0000) | 32'hBEEF);
    wr(A_STS, 32'h2); rd(A_STS, v); chk("R10 eop write-one-clear", v, 32'h0);
    // R8
    wr(MAIN + 32'h22, 32'h1234, 2'd1); wait_op();
    rd(A_ADR, v); chk("R8 address register", v, MAIN + 32'h22);
    rd(A_STS, v); chk("R8 eop set", v, 32'h2);
    rd(MAIN + 32'h20, v); chk("R8 cells unchanged", v, init_word(8));
    wr(A_STS, 32'h2);
    // R7 through alias
    wr(32'h30, 32'h5A5A, 2'd1); wait_op();
    rd(MAIN + 32'h30, v); chk("R7 alias program", v, (init_word(12) & 32'hFFFF_0000) | 32'h5A5A);
    wr(A_STS, 32'h2);
    // R9
    wr(MAIN + 32'h40, 32'h99, 2'd0);
    rd(A_STS, v); chk("R9 byte size error", v, 32'h4);
    wr(MAIN + 32'h44, 32'h1234_5678, 2'd2); wait_op();
    rd(A_STS, v); chk("R9 word size error no op", v, 32'h4);
    rd(MAIN + 32'h40, v); chk("R9 byte not written", v, init_word(16));
    rd(MAIN + 32'h44, v); chk("R9 word not written", v, init_word(17));
    wr(A_STS, 32'hE);
    // R11
    wr(MAIN + 32'h50, 32'h7777, 2'd1); wr(A_CTL, 32'h2); wait_op();
    rd(A_CTL, v); chk("R11 ctrl unchanged", v, 32'h1);
    rd(A_STS, v); chk("R11 busy-write error", v, 32'hA);
    wr(A_STS, 32'hE);
    // R5
    wr(A_CTL, 32'h2); wr(A_ADR, MAIN + 32'h80); wr(A_CTL, 32'h42); wait_op();
    for (int i = 32; i < 64; i++) begin
      rd(MAIN + 32'(i * 4), v); chk("R5 erased word", v, 32'h0);
    end
    rd(MAIN + 32'd124, v); chk("R5 previous page kept", v, init_word(31));
    rd(MAIN + 32'd256, v); chk("R5 next page kept", v, init_word(64));
    rd(32'd160, v); chk("R5 alias of erased page", v, 32'h0);
    rd(A_STS, v); chk("R5 eop", v, 32'h2);
    wr(A_STS, 32'h2);
    // R6
    wr(A_ADR, 32'h100); wr(A_CTL, 32'h42); wait_op();
    rd(A_STS, v); chk("R6 eop on alias erase", v, 32'h2);
    rd(MAIN + 32'h100, v); chk("R6 contents kept", v, init_word(64));
    rd(MAIN + 32'h17C, v); chk("R6 page end kept", v, init_word(95));
    wr(A_STS, 32'h2);
    // R4
    wr(A_CTL, 32'h80); rd(A_CTL, v); chk("R4 relocked", v, 32'h80);
    wr(A_CTL, 32'h1); rd(A_CTL, v); chk("R4 ctrl ignored after relock", v, 32'h80);
    wr(MAIN + 32'h60, 32'h4242, 2'd1); wait_op();
    rd(MAIN + 32'h60, v); chk("R4 program ignored after relock", v, init_word(24));
    rd(A_STS, v); chk("R4 no op started", v, 32'h0);
    wr(A_KEY, K1); wr(A_KEY, K2); rd(A_CTL, v); chk("R4 unlock again", v, 32'h0);
    // R3
    do_reset();
    wr(A_KEY, 32'h1111); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTL, v); chk("R3 wrong key bars unlock", v, 32'h80);
    do_reset();
    wr(A_KEY, K2); wr(A_KEY, K1); wr(A_KEY, K2); wr(A_CTL, 32'h1);
    rd(A_CTL, v); chk("R3 reversed keys bar unlock", v, 32'h80);
    do_reset();
    wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTL, v); chk("R3 reset clears barred state", v, 32'h0);
    report();
  end
endmodule